// File: doc/BRIEF.md
# Pairable Processor Register Storage

This block keeps the working registers of a small 8-bit processor core: six general byte registers, a hidden temporary pair used by the sequencer, a 16-bit stack pointer and a 16-bit program counter. The accumulator and the flags belong to the arithmetic unit, and the stack memory belongs to the memory system. Neither is part of this block.

A byte port reads or writes one general register, chosen by a 3-bit code. A word port reads or writes a pair of general registers as one 16-bit value, chosen by a 2-bit code. One pair code reaches the stack pointer. A separate word port reaches the temporary pair, which the general codes cannot reach. The program counter steps by one after each fetched instruction byte and can be loaded for jumps. The stack pointer steps up or down for pops and pushes and can be loaded.

All state changes on the rising clock edge. Reset is synchronous and active high. Reads are combinational from the stored state, so a read returns the value stored by the most recent edge.

Top module: `rf_core`

## Requirements
- R1: While `rst` is high at a clock edge, all six general registers, the temporary pair, the program counter and the stack pointer become zero.
- R2: Byte codes are B=000, C=001, D=010, E=011, H=100, L=101. A byte write stores `wr8_data` into the coded register at the edge. `rd8_data` shows the coded register. Codes 110 and 111 read as zero, and a write with either code changes no register.
- R3: Pair codes are BC=00, DE=01, HL=10. `rd16_data` shows the first-named register in bits 15:8 and the second-named register in bits 7:0.
- R4: A pair write updates both halves in the same edge, taking bits 15:8 into the high register and bits 7:0 into the low one. Pair code 11 reads and writes the stack pointer.
- R5: If a byte write and a pair write target the same register in one cycle, that register takes the pair-write byte. A byte write to a register outside the pair still takes effect in that cycle.
- R6: `tmp_wr_en` stores `tmp_wr_data` into W (bits 15:8) and Z (bits 7:0), which `tmp_rd_data` shows. No byte code and no pair code reads or changes W or Z.
- R7: `pc_load` loads `pc_load_val`. Otherwise `pc_inc` adds one modulo 2^16. With neither set, the program counter holds. Load wins over increment.
- R8: `sp_inc` adds one to the stack pointer and `sp_dec` subtracts one, both modulo 2^16. Both together, or neither, leave it unchanged.
- R9: Stack pointer priority: `sp_load` first, then a pair write with code 11, then the step controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd8_sel | input | 3 | Byte read code |
| rd8_data | output | 8 | Byte read value |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Byte write code |
| wr8_data | input | 8 | Byte write value |
| rd16_sel | input | 2 | Pair read code |
| rd16_data | output | 16 | Pair read value |
| wr16_en | input | 1 | Pair write enable |
| wr16_sel | input | 2 | Pair write code |
| wr16_data | input | 16 | Pair write value |
| tmp_wr_en | input | 1 | Temporary pair write enable |
| tmp_wr_data | input | 16 | Temporary pair write value |
| tmp_rd_data | output | 16 | Temporary pair value, W high and Z low |
| pc_inc | input | 1 | Program counter step |
| pc_load | input | 1 | Program counter load |
| pc_load_val | input | 16 | Program counter load value |
| pc_out | output | 16 | Program counter |
| sp_inc | input | 1 | Stack pointer step up |
| sp_dec | input | 1 | Stack pointer step down |
| sp_load | input | 1 | Stack pointer load |
| sp_load_val | input | 16 | Stack pointer load value |
| sp_out | output | 16 | Stack pointer |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a byte write and a pair write that land on the same general register. The bench provokes this by writing C while writing BC, and by writing H while writing DE. It then reads each register back, so it can judge both that the pair write won and that the unrelated byte write still took effect.

The second pair is a stack pointer load, a pair write with code 11, and a step, all presented at once. The bench also presents the pair write alone with a step, and the up and down steps together. A behavioural model compares every output on every clock, and randomised traffic keeps creating further coincidences.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned SEL8_W  = 3;
  localparam int unsigned SEL16_W = 2;
  localparam int unsigned NUM_GP  = 6;
  localparam int unsigned NUM_PAIRS = NUM_GP / 2;
  localparam logic [SEL16_W-1:0] PAIR_SP = 2'b11;
endpackage

// File: rtl/rf_ptr_reg.sv
module rf_ptr_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (ld)
      q <= ld_val;
    else if (up && !dn)
      q <= q + ONE;
    else if (dn && !up)
      q <= q - ONE;
  end
endmodule

// File: rtl/rf_gp_bank.sv
module rf_gp_bank
  import rf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr8_en,
  input  logic [SEL8_W-1:0]            wr8_sel,
  input  logic [DW-1:0]                wr8_data,
  input  logic                         wr16_en,
  input  logic [SEL16_W-1:0]           wr16_sel,
  input  logic [2*DW-1:0]              wr16_data,
  output logic [NUM_GP-1:0][DW-1:0]    regs_q
);
  for (genvar i = 0; i < NUM_GP; i++) begin : g_reg
    localparam int unsigned PAIR  = i / 2;
    localparam bit          IS_HI = (i % 2) == 0;
    logic pair_hit, byte_hit;
    logic [DW-1:0] pair_byte;

    assign pair_hit  = wr16_en && (wr16_sel == SEL16_W'(PAIR));
    assign byte_hit  = wr8_en && (wr8_sel == SEL8_W'(i));
    assign pair_byte = IS_HI ? wr16_data[2*DW-1:DW] : wr16_data[DW-1:0];

    always_ff @(posedge clk) begin
      if (rst)
        regs_q[i] <= '0;
      else if (pair_hit)
        regs_q[i] <= pair_byte;
      else if (byte_hit)
        regs_q[i] <= wr8_data;
    end
  end
endmodule

// File: rtl/rf_core.sv
module rf_core
  import rf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          rd8_sel,
  output logic [DW-1:0]       rd8_data,
  input  logic                wr8_en,
  input  logic [2:0]          wr8_sel,
  input  logic [DW-1:0]       wr8_data,
  input  logic [1:0]          rd16_sel,
  output logic [2*DW-1:0]     rd16_data,
  input  logic                wr16_en,
  input  logic [1:0]          wr16_sel,
  input  logic [2*DW-1:0]     wr16_data,
  input  logic                tmp_wr_en,
  input  logic [2*DW-1:0]     tmp_wr_data,
  output logic [2*DW-1:0]     tmp_rd_data,
  input  logic                pc_inc,
  input  logic                pc_load,
  input  logic [2*DW-1:0]     pc_load_val,
  output logic [2*DW-1:0]     pc_out,
  input  logic                sp_inc,
  input  logic                sp_dec,
  input  logic                sp_load,
  input  logic [2*DW-1:0]     sp_load_val,
  output logic [2*DW-1:0]     sp_out
);
  localparam int unsigned AW = 2 * DW;

  logic [NUM_GP-1:0][DW-1:0] gp_q;
  logic                      sp_ld;
  logic [AW-1:0]             sp_ld_val;

  rf_gp_bank #(.DW(DW)) i_bank (
    .clk(clk), .rst(rst),
    .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
    .wr16_en(wr16_en), .wr16_sel(wr16_sel), .wr16_data(wr16_data),
    .regs_q(gp_q)
  );

  // Stack pointer: explicit load ahead of pair write, both ahead of stepping
  assign sp_ld     = sp_load || (wr16_en && wr16_sel == PAIR_SP);
  assign sp_ld_val = sp_load ? sp_load_val : wr16_data;

  rf_ptr_reg #(.W(AW)) i_sp (
    .clk(clk), .rst(rst), .ld(sp_ld), .ld_val(sp_ld_val),
    .up(sp_inc), .dn(sp_dec), .q(sp_out)
  );

  rf_ptr_reg #(.W(AW)) i_pc (
    .clk(clk), .rst(rst), .ld(pc_load), .ld_val(pc_load_val),
    .up(pc_inc), .dn(1'b0), .q(pc_out)
  );

  // Temporary pair: a plain loadable word that never steps
  rf_ptr_reg #(.W(AW)) i_tmp (
    .clk(clk), .rst(rst), .ld(tmp_wr_en), .ld_val(tmp_wr_data),
    .up(1'b0), .dn(1'b0), .q(tmp_rd_data)
  );

  always_comb begin
    rd8_data = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (rd8_sel == SEL8_W'(i)) rd8_data = gp_q[i];
  end

  always_comb begin
    rd16_data = sp_out;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (rd16_sel == SEL16_W'(p)) rd16_data = {gp_q[2*p], gp_q[2*p+1]};
  end
endmodule

// File: rtl/rf_core_chk.sv
module rf_core_chk #(
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr16_en,
  input logic [1:0]      wr16_sel,
  input logic [2*DW-1:0] wr16_data,
  input logic            tmp_wr_en,
  input logic [2*DW-1:0] tmp_wr_data,
  input logic [2*DW-1:0] tmp_rd_data,
  input logic            pc_inc,
  input logic            pc_load,
  input logic [2*DW-1:0] pc_load_val,
  input logic [2*DW-1:0] pc_out,
  input logic            sp_inc,
  input logic            sp_dec,
  input logic            sp_load,
  input logic [2*DW-1:0] sp_load_val,
  input logic [2*DW-1:0] sp_out
);
  localparam logic [2*DW-1:0] ONE = (2*DW)'(1);
  logic sp_pair;
  assign sp_pair = wr16_en && (wr16_sel == 2'b11);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc_out == '0 && sp_out == '0 && tmp_rd_data == '0));

  p_tmp_wr_r6: assert property (@(posedge clk) disable iff (rst)
    tmp_wr_en |=> tmp_rd_data == $past(tmp_wr_data));
  p_tmp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tmp_wr_en |=> $stable(tmp_rd_data));

  p_pc_load_r7: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> pc_out == $past(pc_load_val));
  p_pc_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (!pc_load && pc_inc) |=> pc_out == $past(pc_out) + ONE);
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!pc_load && !pc_inc) |=> $stable(pc_out));

  p_sp_load_r9: assert property (@(posedge clk) disable iff (rst)
    sp_load |=> sp_out == $past(sp_load_val));
  p_sp_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (!sp_load && sp_pair) |=> sp_out == $past(wr16_data));
  p_sp_up_r8: assert property (@(posedge clk) disable iff (rst)
    (!sp_load && !sp_pair && sp_inc && !sp_dec) |=> sp_out == $past(sp_out) + ONE);
  p_sp_down_r8: assert property (@(posedge clk) disable iff (rst)
    (!sp_load && !sp_pair && sp_dec && !sp_inc) |=> sp_out == $past(sp_out) - ONE);
  p_sp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!sp_load && !sp_pair && (sp_inc == sp_dec)) |=> $stable(sp_out));
endmodule

bind rf_core rf_core_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_rf_core.sv
module test_rf_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [2:0]  rd8_sel, wr8_sel;
  logic [7:0]  rd8_data, wr8_data;
  logic        wr8_en, wr16_en, tmp_wr_en;
  logic [1:0]  rd16_sel, wr16_sel;
  logic [15:0] rd16_data, wr16_data, tmp_wr_data, tmp_rd_data;
  logic        pc_inc, pc_load, sp_inc, sp_dec, sp_load;
  logic [15:0] pc_load_val, pc_out, sp_load_val, sp_out;

  rf_core i_rf_core (.*);

  // behavioural reference
  logic [7:0]  m_gp [6];
  logic [15:0] m_tmp, m_pc, m_sp;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; wr8_en = 0; wr16_en = 0; tmp_wr_en = 0;
    pc_inc = 0; pc_load = 0; sp_inc = 0; sp_dec = 0; sp_load = 0;
  endtask

  task automatic model_edge();
    if (rst) begin
      foreach (m_gp[i]) m_gp[i] = 8'h00;
      m_tmp = 0; m_pc = 0; m_sp = 0;
    end else begin
      if (wr8_en && wr8_sel < 6) m_gp[wr8_sel] = wr8_data;          // R2
      if (wr16_en && wr16_sel < 3) begin                              // R4, R5
        m_gp[2*wr16_sel]   = wr16_data[15:8];
        m_gp[2*wr16_sel+1] = wr16_data[7:0];
      end
      if (tmp_wr_en) m_tmp = tmp_wr_data;                             // R6
      if (pc_load) m_pc = pc_load_val;                                // R7
      else if (pc_inc) m_pc = m_pc + 16'd1;
      if (sp_load) m_sp = sp_load_val;                                // R9
      else if (wr16_en && wr16_sel == 2'b11) m_sp = wr16_data;
      else if (sp_inc && !sp_dec) m_sp = m_sp + 16'd1;                // R8
      else if (sp_dec && !sp_inc) m_sp = m_sp - 16'd1;
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(req, "rd8",  {8'h00, rd8_data}, {8'h00, (rd8_sel < 6) ? m_gp[rd8_sel] : 8'h00});
    chk(req, "rd16", rd16_data,
        (rd16_sel == 2'b11) ? m_sp : {m_gp[2*rd16_sel], m_gp[2*rd16_sel+1]});
    chk(req, "tmp", tmp_rd_data, m_tmp);
    chk(req, "pc",  pc_out, m_pc);
    chk(req, "sp",  sp_out, m_sp);
    idle();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rd8_sel = 0; rd16_sel = 0; wr8_sel = 0; wr16_sel = 0;
    wr8_data = 0; wr16_data = 0; tmp_wr_data = 0; pc_load_val = 0; sp_load_val = 0;
    // R1: reset with dirty stimulus held off
    rst = 1; step("R1");
    rst = 1; pc_inc = 1; sp_dec = 1; step("R1");
    step("R1");

    // R2: write every byte code, including 110 and 111, then read all back
    for (int i = 0; i < 8; i++) begin
      wr8_en = 1; wr8_sel = 3'(i); wr8_data = 8'h30 + 8'(i); rd8_sel = 3'(i); step("R2");
    end
    for (int i = 0; i < 8; i++) begin rd8_sel = 3'(i); step("R2"); end

    // R4 / R3: pair writes and half reads
    for (int p = 0; p < 3; p++) begin
      wr16_en = 1; wr16_sel = 2'(p); wr16_data = 16'hA1B2 + 16'(p * 16'h1111);
      rd16_sel = 2'(p); step("R4");
      rd8_sel = 3'(2*p);   rd16_sel = 2'(p); step("R3");
      rd8_sel = 3'(2*p+1); step("R3");
    end
    wr16_en = 1; wr16_sel = 2'b11; wr16_data = 16'h7F00; rd16_sel = 2'b11; step("R4");

    // R5: byte and pair write on same register, and on a foreign register
    wr8_en = 1; wr8_sel = 3'd1; wr8_data = 8'h55;
    wr16_en = 1; wr16_sel = 2'b00; wr16_data = 16'h1234; rd8_sel = 3'd1; step("R5");
    rd8_sel = 3'd1; step("R5");
    rd8_sel = 3'd0; step("R5");
    wr8_en = 1; wr8_sel = 3'd4; wr8_data = 8'h9C;
    wr16_en = 1; wr16_sel = 2'b01; wr16_data = 16'hDEAD; rd8_sel = 3'd4; rd16_sel = 2'b01; step("R5");
    rd8_sel = 3'd4; rd16_sel = 2'b10; step("R5");

    // R6: temporary pair, untouched by any code
    tmp_wr_en = 1; tmp_wr_data = 16'hBEEF; step("R6");
    for (int i = 0; i < 8; i++) begin
      wr8_en = 1; wr8_sel = 3'(i); wr8_data = 8'hE0 + 8'(i);
      wr16_en = 1; wr16_sel = 2'(i % 4); wr16_data = 16'h0F0F; step("R6");
    end
    for (int i = 0; i < 4; i++) begin rd16_sel = 2'(i); step("R6"); end

    // R7: program counter load, wrap and priority
    pc_load = 1; pc_load_val = 16'hFFFE; step("R7");
    pc_inc = 1; step("R7");
    pc_inc = 1; step("R7");
    step("R7");
    pc_inc = 1; pc_load = 1; pc_load_val = 16'h4000; step("R7");

    // R8: stack pointer stepping and wrap
    sp_load = 1; sp_load_val = 16'h0001; step("R8");
    sp_dec = 1; step("R8");
    sp_dec = 1; step("R8");
    sp_inc = 1; step("R8");
    sp_inc = 1; sp_dec = 1; step("R8");

    // R9: stack pointer source priority
    sp_load = 1; sp_load_val = 16'h2222; wr16_en = 1; wr16_sel = 2'b11;
    wr16_data = 16'h3333; sp_dec = 1; step("R9");
    wr16_en = 1; wr16_sel = 2'b11; wr16_data = 16'h4444; sp_inc = 1; step("R9");
    sp_load = 1; sp_load_val = 16'h5555; sp_inc = 1; step("R9");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      rd8_sel = 3'($urandom); rd16_sel = 2'($urandom);
      wr8_en = 1'($urandom); wr8_sel = 3'($urandom); wr8_data = 8'($urandom);
      wr16_en = ($urandom % 3) == 0; wr16_sel = 2'($urandom); wr16_data = 16'($urandom);
      tmp_wr_en = ($urandom % 4) == 0; tmp_wr_data = 16'($urandom);
      pc_inc = 1'($urandom); pc_load = ($urandom % 8) == 0; pc_load_val = 16'($urandom);
      sp_inc = 1'($urandom); sp_dec = 1'($urandom);
      sp_load = ($urandom % 8) == 0; sp_load_val = 16'($urandom);
      rst = ($urandom % 200) == 0;
      step("R4");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule